// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Array

This block is a programmable logic array. It has an AND plane, an OR plane and a per-output polarity stage, and a fuse map sets all three. After reset the array is empty. A serial loader accepts the fuse map one bit per clock, in a fixed order. When the last fuse has been accepted, a done flag rises. From then on, the output vector is a purely combinational function of the input vector and the stored fuses.

Each product term sees every input through two fuses, one on the true side and one on the complement side. A term is active when every input position selected by the input mask satisfies both `(true_fuse | x)` and `(comp_fuse | ~x)`.

- Both fuses at 1 make the input a don't-care.
- A true fuse of 0 with a complement fuse of 1 requires the input to be 1.
- A true fuse of 1 with a complement fuse of 0 requires the input to be 0.
- Both fuses at 0 make the term impossible.

An OR-plane fuse of 0 connects a term to an output. An OR-plane fuse of 1 leaves it disconnected. A final polarity fuse of 1 inverts that output.

Two parameter sets are intended: 16 inputs, 48 terms and 8 outputs with a full 16-bit mask, and 27 inputs, 48 terms and 18 outputs with a full 27-bit mask.

Top module: `fuse_pla`

## Requirements
- R1: Fuses are accepted one per clock on a rising edge where `fuse_valid` is high. The order is term 0 first, then each following term. Within a term, the inputs come from index 0 upward, and each input gives two fuses: the complement-side fuse, then the true-side fuse. These are followed by that term's OR fuses, one per output from output 0 upward. After the last term come the polarity fuses, one per output from output 0 upward. Clock edges with `fuse_valid` low accept nothing.
- R2: `load_done` rises in the cycle after exactly `TERMS*(2*INPUTS+OUTPUTS)+OUTPUTS` fuses have been accepted, and not earlier.
- R3: While `load_done` is low, `out_vec` is all zeros whatever the input vector.
- R4: A product term is active exactly when, for every masked input bit x, both `(true_fuse | x)` and `(comp_fuse | ~x)` equal 1.
- R5: Each output's raw value is the OR of all active terms whose OR fuse for that output is 0. An OR fuse of 1 disconnects the term from that output.
- R6: Each output equals its raw value XORed with its polarity fuse.
- R7: An input position whose bit in `IN_MASK` is 0 has no effect on any output.
- R8: A term with both fuses at 0 for the same masked input is never active.
- R9: A term whose fuses are all 1 is always active and drives no output.
- R10: Fuses offered while `load_done` is high are ignored and leave the outputs unchanged. A `restart` pulse clears the count and the storage, drops `load_done`, and allows a fresh full load.
- R11: After a synchronous active-low reset, `load_done` is low and `out_vec` is zero.
- R12: Once loaded, `out_vec` follows `in_vec` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse loader |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous clear of the fuse count and storage |
| fuse_valid | input | 1 | Fuse strobe; one fuse per clock while high |
| fuse_bit | input | 1 | Value of the fuse being offered |
| load_done | output | 1 | High once the full fuse map is stored |
| in_vec | input | INPUTS | Input vector to the AND plane |
| out_vec | output | OUTPUTS | Polarity-adjusted outputs |

## Verification
The bench builds the block with 4 inputs, 4 terms and 3 outputs, using a mask of `4'b0111`. With these values the 47-fuse map is short enough to write term by term, and all 16 input vectors can be walked in one table. The masked-off top input lets the table check that such a position is ignored. The four terms cover four cases: a mixed literal term, a term that requires the masked-off input, a term that can never be active, and a term that is always active but drives nothing. This puts the impossible-term and dead-term rules within reach alongside inverted polarity.

// File: rtl/fuse_pla_pkg.sv
// Package: shared sizing helpers for the fuse-programmable array.
// Assumes: all counts are positive; fuse layout is term-major as in BRIEF R1.
package fuse_pla_pkg;

    // Width of one term's fuse row: two per input plus one per output.
    function automatic int row_width(input int n_in, input int n_out);
        return 2 * n_in + n_out;
    endfunction

    // Total number of fuses in a full map, polarity fuses included.
    function automatic int fuse_total(input int n_in, input int n_term, input int n_out);
        return n_term * row_width(n_in, n_out) + n_out;
    endfunction

endpackage

// File: rtl/fuse_pla_loader.sv
// Module: serial fuse loader. It shifts fuses into a flat store and counts them.
// Assumes: exactly TOTAL fuses are shifted per load, so fuse k ends at store bit k.
module fuse_pla_loader #(
    parameter int TOTAL = 1928
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fuse_valid,
    input  logic             fuse_bit,
    output logic             load_done,
    output logic [TOTAL-1:0] store_q
);
    localparam int CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] FULL = CW'(TOTAL);

    logic [CW-1:0] cnt_q;
    logic          take;

    // Accept a fuse only while the map is incomplete.
    always_comb take = fuse_valid && (cnt_q != FULL);

    // Count accepted fuses; reset and restart clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (take)
            cnt_q <= cnt_q + 1'b1;
    end

    // Shift each accepted fuse in from the top; the earliest fuse settles at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            store_q <= '0;
        else if (take)
            store_q <= {fuse_bit, store_q[TOTAL-1:1]};
    end

    // Done flag decoded from the count.
    always_comb load_done = (cnt_q == FULL);

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    a_r1_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && fuse_valid && !load_done) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !fuse_valid) |=> $stable(cnt_q));
    a_r10_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !restart) |=> $stable(store_q));
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0 && !load_done));
endmodule

// File: rtl/fuse_pla_and_plane.sv
// Module: AND plane. It evaluates every product term against the input vector.
// Assumes: the fuse row layout from the package; masked-off inputs never veto a term.
module fuse_pla_and_plane #(
    parameter int              INPUTS  = 16,
    parameter int              TERMS   = 48,
    parameter int              OUTPUTS = 8,
    parameter logic [INPUTS-1:0] IN_MASK = {INPUTS{1'b1}},
    parameter int              TOTAL   = fuse_pla_pkg::fuse_total(INPUTS, TERMS, OUTPUTS)
) (
    input  logic [TOTAL-1:0]  fuses,
    input  logic [INPUTS-1:0] in_vec,
    output logic [TERMS-1:0]  term_hit
);
    localparam int ROW = fuse_pla_pkg::row_width(INPUTS, OUTPUTS);

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic [INPUTS-1:0] comp_f;
        logic [INPUTS-1:0] true_f;
        logic [INPUTS-1:0] lit_ok;

        for (genvar i = 0; i < INPUTS; i++) begin : g_in
            // Pick this input's complement fuse and true fuse from the term row.
            assign comp_f[i] = fuses[t*ROW + 2*i];
            assign true_f[i] = fuses[t*ROW + 2*i + 1];
        end

        // A literal passes when both sides allow it, or when its input is masked off.
        always_comb lit_ok = ((true_f | in_vec) & (comp_f | ~in_vec)) | ~IN_MASK;
        // The term is active when every literal passes.
        always_comb term_hit[t] = &lit_ok;
    end
endmodule

// File: rtl/fuse_pla_or_plane.sv
// Module: OR plane and polarity stage. It gathers active terms onto outputs.
// Assumes: an OR fuse of 0 connects; outputs stay zero until the map is complete.
module fuse_pla_or_plane #(
    parameter int INPUTS  = 16,
    parameter int TERMS   = 48,
    parameter int OUTPUTS = 8,
    parameter int TOTAL   = fuse_pla_pkg::fuse_total(INPUTS, TERMS, OUTPUTS)
) (
    input  logic [TOTAL-1:0]   fuses,
    input  logic [TERMS-1:0]   term_hit,
    input  logic               load_done,
    output logic [OUTPUTS-1:0] out_vec
);
    localparam int ROW    = fuse_pla_pkg::row_width(INPUTS, OUTPUTS);
    localparam int XOR_AT = TERMS * ROW;

    logic [OUTPUTS-1:0] raw;
    logic [OUTPUTS-1:0] pol;

    for (genvar o = 0; o < OUTPUTS; o++) begin : g_out
        logic [TERMS-1:0] link;
        for (genvar t = 0; t < TERMS; t++) begin : g_link
            // An OR fuse at zero links term t to output o.
            assign link[t] = ~fuses[t*ROW + 2*INPUTS + o];
        end
        // Raw sum: any linked active term raises the output.
        always_comb raw[o] = |(link & term_hit);
        // Polarity fuse for this output.
        assign pol[o] = fuses[XOR_AT + o];
    end

    // Apply polarity, and hold the outputs at zero until the load finishes.
    always_comb out_vec = load_done ? (raw ^ pol) : '0;
endmodule

// File: rtl/fuse_pla.sv
// Module: top of the fuse-programmable sum-of-products array.
// Assumes: the fuse map is loaded serially after reset; in_vec is used only once loaded.
module fuse_pla #(
    parameter int                INPUTS  = 16,
    parameter int                TERMS   = 48,
    parameter int                OUTPUTS = 8,
    parameter logic [INPUTS-1:0] IN_MASK = {INPUTS{1'b1}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               fuse_valid,
    input  logic               fuse_bit,
    output logic               load_done,
    input  logic [INPUTS-1:0]  in_vec,
    output logic [OUTPUTS-1:0] out_vec
);
    localparam int TOTAL = fuse_pla_pkg::fuse_total(INPUTS, TERMS, OUTPUTS);

    logic [TOTAL-1:0] fuses;
    logic [TERMS-1:0] term_hit;

    fuse_pla_loader #(.TOTAL(TOTAL)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .fuse_valid (fuse_valid),
        .fuse_bit   (fuse_bit),
        .load_done  (load_done),
        .store_q    (fuses)
    );

    fuse_pla_and_plane #(
        .INPUTS(INPUTS), .TERMS(TERMS), .OUTPUTS(OUTPUTS),
        .IN_MASK(IN_MASK), .TOTAL(TOTAL)
    ) u_and (
        .fuses    (fuses),
        .in_vec   (in_vec),
        .term_hit (term_hit)
    );

    fuse_pla_or_plane #(
        .INPUTS(INPUTS), .TERMS(TERMS), .OUTPUTS(OUTPUTS), .TOTAL(TOTAL)
    ) u_or (
        .fuses     (fuses),
        .term_hit  (term_hit),
        .load_done (load_done),
        .out_vec   (out_vec)
    );

    a_r3_quiet_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (out_vec == '0));
endmodule

// File: tb/fuse_pla_tb.sv
module fuse_pla_tb;
    localparam int N = 4, T = 4, O = 3;
    localparam int TOTAL = T * (2*N + O) + O;   // 47
    localparam logic [N-1:0] MASK = 4'b0111;

    // AND fuses per term: complement fuse at bit 2i, true fuse at bit 2i+1.
    localparam logic [7:0] AND_SPEC [T] = '{8'hF9, 8'h5F, 8'hFC, 8'hFF};
    // OR fuses per term, bit o for output o (0 = linked).
    localparam logic [2:0] OR_SPEC [T] = '{3'b110, 3'b001, 3'b000, 3'b111};
    // Table rows: {in_vec, expected out_vec}, for polarity fuses 3'b100.
    localparam logic [6:0] VEC [16] = '{
        {4'd0, 3'b100}, {4'd1, 3'b101}, {4'd2, 3'b100}, {4'd3, 3'b100},
        {4'd4, 3'b010}, {4'd5, 3'b011}, {4'd6, 3'b010}, {4'd7, 3'b010},
        {4'd8, 3'b100}, {4'd9, 3'b101}, {4'd10, 3'b100}, {4'd11, 3'b100},
        {4'd12, 3'b010}, {4'd13, 3'b011}, {4'd14, 3'b010}, {4'd15, 3'b010}};

    logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, fuse_valid = 1'b0, fuse_bit = 1'b0;
    logic [N-1:0] in_vec = '0;
    logic load_done;
    logic [O-1:0] out_vec;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fuse_pla #(.INPUTS(N), .TERMS(T), .OUTPUTS(O), .IN_MASK(MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .fuse_valid(fuse_valid),
        .fuse_bit(fuse_bit), .load_done(load_done), .in_vec(in_vec), .out_vec(out_vec));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic b);
        @(negedge clk);
        fuse_valid = 1'b1;
        fuse_bit   = b;
        @(posedge clk);
        #1 fuse_valid = 1'b0;
    endtask

    // Push fuse number k of the map, using polarity fuses pol.
    function automatic logic fuse_at(input int k, input logic [2:0] pol);
        int row = 2*N + O;
        if (k >= T*row) return pol[k - T*row];
        if ((k % row) < 2*N) return AND_SPEC[k / row][k % row];
        return OR_SPEC[k / row][(k % row) - 2*N];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        in_vec = 4'b0001;
        #1;
        check("R11 done in reset", 32'(load_done), 0);
        check("R11 out in reset", 32'(out_vec), 0);
        @(negedge clk) rst_n = 1'b1;

        // Partial load with idle gaps (R1, R2, R3).
        for (int k = 0; k < TOTAL - 1; k++) begin
            push(fuse_at(k, 3'b100));
            if (k == 10) repeat (3) @(posedge clk);
        end
        #1;
        check("R2 not done one fuse short", 32'(load_done), 0);
        check("R3 out zero while partial", 32'(out_vec), 0);
        push(fuse_at(TOTAL - 1, 3'b100));
        #1;
        check("R2 done after full count", 32'(load_done), 1);

        // Table walk: R4 R5 R6 R7 R8 R9, inputs changed between edges (R12).
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            in_vec = VEC[v][6:3];
            #2;
            check("R4/R5/R6/R7/R8/R9 table", 32'(out_vec), 32'(VEC[v][2:0]));
        end

        // R12: change without any clock edge in between.
        @(posedge clk);
        #3 in_vec = 4'd5;
        #1 check("R12 comb follow a", 32'(out_vec), 3'b011);
        in_vec = 4'd4;
        #1 check("R12 comb follow b", 32'(out_vec), 3'b010);

        // R10: fuses offered while done are ignored.
        for (int k = 0; k < TOTAL; k++) push(1'b0);
        in_vec = 4'd1;
        #1;
        check("R10 done kept", 32'(load_done), 1);
        check("R10 ignored writes", 32'(out_vec), 3'b101);

        // R10: restart clears the array, then reload with no inversion.
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        check("R10 restart drops done", 32'(load_done), 0);
        check("R10 restart quiets out", 32'(out_vec), 0);
        for (int k = 0; k < TOTAL; k++) push(fuse_at(k, 3'b000));
        #1;
        check("R10 reload done", 32'(load_done), 1);
        in_vec = 4'd0;
        #1 check("R6 zero polarity x=0", 32'(out_vec), 3'b000);
        in_vec = 4'd13;
        #1 check("R6 zero polarity x=13", 32'(out_vec), 3'b111);

        finished = 1'b1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule